// File: doc/BRIEF.md
# Sliding 3x3 Pixel Window Loader

This block is the bus-facing front end of a window-based pixel filter. A host writes pixels into a small bank of slot registers over a simple single-cycle register bus. It then issues a start command. The block turns the slots into a 3x3 window, holds the window on a wide output bus, and pulses a launch strobe to the downstream filter datapath. When the datapath returns its filtered pixel, the block stores it in a read-only result register. It then sets a done flag and, if enabled, raises a level interrupt.

A row begins with a start command in full-load mode, which takes all nine slots. As the window slides one column to the right, each later start command in shift mode keeps the six newest pixels already in the window and takes only three fresh pixels from slots 1 to 3. This cuts the host's writes per output pixel from nine to three.

The control register sits at offset 0. Bit 0 is start and always reads 0. Bit 1 is done and is cleared by writing 1 to it. Bit 2 enables the interrupt. Bit 3 selects full-load mode. Bit 4 is a read-only busy flag. Offsets 1 to 9 are the pixel slots. Offset 10 is the result register. Other offsets read as zero.

Top module: `pix_window_loader`

## Requirements
- R1: After reset the control register reads 0, the result register reads 0, the interrupt is low and the launch strobe is low.
- R2: A start write that also sets bit 3 loads window position k (0 to 8) from slot k+1. Positions 0-2 form the left column, 3-5 the middle column and 6-8 the right column, each listed top to bottom. Position k occupies bits [k*PIX_W +: PIX_W] of the window bus. The launch strobe is high for exactly the one cycle after the start write.
- R3: A start write with bit 3 clear moves the middle column into the left column and the right column into the middle column. Slots 1, 2 and 3 become the new right column. Slots 4 to 9 have no effect in this mode.
- R4: The start bit (bit 0) always reads 0. The busy bit (bit 4) reads 1 from the cycle after an accepted start until the result is captured.
- R5: A result-valid input while busy stores the filtered pixel in the result register (offset 10), sets done (bit 1) and clears busy.
- R6: The interrupt output is high exactly while done and the interrupt-enable bit (bit 2) are both 1.
- R7: Done, and with it the interrupt, is cleared by a control write with bit 1 set, or by an accepted start.
- R8: A start write while busy is ignored. No launch strobe follows, the window is unchanged and busy stays high. Bits 2 and 3 of that write are still stored.
- R9: The result register keeps its value until the next completion. A result-valid input while not busy is ignored.
- R10: Writes to offset 10 have no effect on the result register.
- R11: A pixel slot stores the low PIX_W bits of a write and reads them back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W (4) | Register offset |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data for busAddr, combinational |
| winValid | output | 1 | One-cycle launch strobe for a new window |
| winPixels | output | 9*PIX_W (216) | Current window, position k at [k*PIX_W +: PIX_W] |
| filtValid | input | 1 | Filtered pixel valid from datapath |
| filtPixel | input | PIX_W (24) | Filtered pixel from datapath |
| irq | output | 1 | Level interrupt, done and enabled |

## Verification
The checker watches several rules on every cycle. Busy and done are never both set. Done rises only after a result-valid input that arrives while busy. A start written while busy never produces a launch. Every launch happens while busy. A shift-mode launch presents the old middle and right columns as the new left and middle. The result holds between completions. A done-clear write removes done and the interrupt. The directed scenarios alone show the exact slot-to-position mapping and the right column taken from slots 1 to 3. They also show the read-back values, the read-only result offset, gating of the interrupt by its enable, and the full sequence of loading a row and then shifting along it.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  // Bit positions in the control register
  localparam int CTRL_START = 0;
  localparam int CTRL_DONE  = 1;
  localparam int CTRL_IRQEN = 2;
  localparam int CTRL_FULL  = 3;
  localparam int CTRL_BUSY  = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAll;   // full-window load from every slot
    logic shiftCol;  // shift by one column, new right column from slots
    logic capture;   // latch filtered pixel into result
  } pwlStrobes_t;
endpackage

// File: rtl/pwl_ctrl.sv
module pwl_ctrl
  import pwl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              filtValid,
  output pwlStrobes_t       strobes,
  output logic              busyQ,
  output logic              doneQ,
  output logic              winValidQ,
  output logic              irq,
  output logic [DATA_W-1:0] statusWord
);
  logic ctrlWr;
  logic startReq;
  logic startOk;
  logic irqEnQ;
  logic fullModeQ;

  assign ctrlWr   = busWe && (busAddr == '0);
  assign startReq = ctrlWr && busWdata[CTRL_START];
  assign startOk  = startReq && !busyQ;

  always_comb begin
    strobes.loadAll  = startOk && busWdata[CTRL_FULL];
    strobes.shiftCol = startOk && !busWdata[CTRL_FULL];
    strobes.capture  = filtValid && busyQ;
  end

  // busy: set by an accepted start, cleared by capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (startOk) begin
      busyQ <= 1'b1;
    end else if (strobes.capture) begin
      busyQ <= 1'b0;
    end
  end

  // done: set by capture, cleared by start or write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
    end else if (strobes.capture) begin
      doneQ <= 1'b1;
    end else if (startOk) begin
      doneQ <= 1'b0;
    end else if (ctrlWr && busWdata[CTRL_DONE]) begin
      doneQ <= 1'b0;
    end
  end

  // configuration bits, written on every control write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnQ    <= 1'b0;
      fullModeQ <= 1'b0;
    end else if (ctrlWr) begin
      irqEnQ    <= busWdata[CTRL_IRQEN];
      fullModeQ <= busWdata[CTRL_FULL];
    end
  end

  // launch strobe, one cycle after the accepted start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winValidQ <= 1'b0;
    end else begin
      winValidQ <= startOk;
    end
  end

  assign irq = doneQ && irqEnQ;

  always_comb begin
    statusWord             = '0;
    statusWord[CTRL_DONE]  = doneQ;
    statusWord[CTRL_IRQEN] = irqEnQ;
    statusWord[CTRL_FULL]  = fullModeQ;
    statusWord[CTRL_BUSY]  = busyQ;
  end
endmodule

// File: rtl/pwl_datapath.sv
module pwl_datapath
  import pwl_pkg::*;
#(
  parameter int PIX_W   = 24,
  parameter int WIN_DIM = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWe,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWdata,
  input  pwlStrobes_t                strobes,
  input  logic [DATA_W-1:0]          statusWord,
  input  logic [PIX_W-1:0]           filtPixel,
  output logic [DATA_W-1:0]          busRdata,
  output logic [WIN_DIM*WIN_DIM*PIX_W-1:0] winPixels,
  output logic [PIX_W-1:0]           resultQ
);
  localparam int WIN_N    = WIN_DIM * WIN_DIM;
  localparam int KEEP_N   = WIN_N - WIN_DIM;
  localparam int RES_ADDR = WIN_N + 1;

  logic [PIX_W-1:0] slotQ [WIN_N];
  logic [PIX_W-1:0] winQ  [WIN_N];

  // slot bank, slot s+1 on the bus maps to slotQ[s]
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < WIN_N; s++) slotQ[s] <= '0;
    end else if (busWe) begin
      for (int s = 0; s < WIN_N; s++) begin
        if (busAddr == ADDR_W'(s + 1)) slotQ[s] <= busWdata[PIX_W-1:0];
      end
    end
  end

  // window register: full load or one-column shift
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < WIN_N; k++) winQ[k] <= '0;
    end else if (strobes.loadAll) begin
      for (int k = 0; k < WIN_N; k++) winQ[k] <= slotQ[k];
    end else if (strobes.shiftCol) begin
      for (int k = 0; k < KEEP_N; k++) winQ[k] <= winQ[k + WIN_DIM];
      for (int r = 0; r < WIN_DIM; r++) winQ[KEEP_N + r] <= slotQ[r];
    end
  end

  // result register, only the datapath capture writes it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
    end else if (strobes.capture) begin
      resultQ <= filtPixel;
    end
  end

  for (genvar g = 0; g < WIN_N; g++) begin : g_winOut
    assign winPixels[g*PIX_W +: PIX_W] = winQ[g];
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == '0) begin
      busRdata = statusWord;
    end else if (busAddr == ADDR_W'(RES_ADDR)) begin
      busRdata[PIX_W-1:0] = resultQ;
    end else begin
      for (int s = 0; s < WIN_N; s++) begin
        if (busAddr == ADDR_W'(s + 1)) busRdata[PIX_W-1:0] = slotQ[s];
      end
    end
  end
endmodule

// File: rtl/pix_window_loader.sv
module pix_window_loader
  import pwl_pkg::*;
#(
  parameter int PIX_W   = 24,
  parameter int WIN_DIM = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busWe,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [DATA_W-1:0]                busWdata,
  output logic [DATA_W-1:0]                busRdata,
  output logic                             winValid,
  output logic [WIN_DIM*WIN_DIM*PIX_W-1:0] winPixels,
  input  logic                             filtValid,
  input  logic [PIX_W-1:0]                 filtPixel,
  output logic                             irq
);
  pwlStrobes_t      strobes;
  logic             busyQ;
  logic             doneQ;
  logic [DATA_W-1:0] statusWord;
  logic [PIX_W-1:0] resultQ;

  pwl_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .filtValid(filtValid), .strobes(strobes),
    .busyQ(busyQ), .doneQ(doneQ), .winValidQ(winValid), .irq(irq),
    .statusWord(statusWord)
  );

  pwl_datapath #(.PIX_W(PIX_W), .WIN_DIM(WIN_DIM), .ADDR_W(ADDR_W),
                 .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .strobes(strobes), .statusWord(statusWord),
    .filtPixel(filtPixel), .busRdata(busRdata), .winPixels(winPixels),
    .resultQ(resultQ)
  );
endmodule

// File: rtl/pwl_checker.sv
module pwl_checker #(
  parameter int PIX_W   = 24,
  parameter int WIN_DIM = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             busWe,
  input logic [ADDR_W-1:0]                busAddr,
  input logic [DATA_W-1:0]                busWdata,
  input logic                             winValid,
  input logic [WIN_DIM*WIN_DIM*PIX_W-1:0] winPixels,
  input logic                             filtValid,
  input logic                             irq,
  input logic                             busyQ,
  input logic                             doneQ,
  input logic [PIX_W-1:0]                 resultQ
);
  localparam int KEEP_W = (WIN_DIM * WIN_DIM - WIN_DIM) * PIX_W;
  localparam int COL_W  = WIN_DIM * PIX_W;

  logic ctrlWr;
  assign ctrlWr = busWe && (busAddr == '0);

  p_launch_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> busyQ);

  p_done_busy_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(doneQ && busyQ));

  p_done_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(filtValid && busyQ));

  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && ctrlWr && busWdata[0]) |=> !winValid);

  p_shift_reuse_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWdata[0] && !busWdata[3] && !busyQ) |=>
      (winPixels[KEEP_W-1:0] == $past(winPixels[COL_W +: KEEP_W])));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(filtValid && busyQ) |=> $stable(resultQ));

  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWdata[1] && !busyQ) |=> (!doneQ && !irq));
endmodule

bind pix_window_loader pwl_checker #(
  .PIX_W(PIX_W), .WIN_DIM(WIN_DIM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .winValid(winValid), .winPixels(winPixels),
  .filtValid(filtValid), .irq(irq), .busyQ(busyQ), .doneQ(doneQ),
  .resultQ(resultQ)
);

// File: tb/pix_window_loader_bench.sv
`timescale 1ns/1ps
module pix_window_loader_bench;
  localparam int PIX_W = 24;
  localparam int WIN_N = 9;
  localparam int AW    = 4;
  localparam int DW    = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic winValid;
  logic [WIN_N*PIX_W-1:0] winPixels;
  logic filtValid = 1'b0;
  logic [PIX_W-1:0] filtPixel = '0;
  logic irq;

  int nChecks = 0;
  int nFails  = 0;
  logic [PIX_W-1:0] expWin [WIN_N];

  always #2 clk = ~clk;

  pix_window_loader u_pix_window_loader (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .winValid(winValid),
    .winPixels(winPixels), .filtValid(filtValid), .filtPixel(filtPixel),
    .irq(irq)
  );

  task automatic check(input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WIN_N*PIX_W-1:0] packWin();
    logic [WIN_N*PIX_W-1:0] v;
    for (int k = 0; k < WIN_N; k++) v[k*PIX_W +: PIX_W] = expWin[k];
    return v;
  endfunction

  // one write cycle; returns at the negedge after the capturing edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  task automatic complete(input logic [PIX_W-1:0] p);
    @(negedge clk);
    filtValid = 1'b1; filtPixel = p;
    @(negedge clk);
    filtValid = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    rd(0, d);  check("R1 ctrl", d, 0);
    rd(10, d); check("R1 result", d, 0);
    check("R1 irq", irq, 0);
    check("R1 winValid", winValid, 0);
  endtask

  task automatic t_full_load();
    logic [DW-1:0] d;
    for (int s = 1; s <= WIN_N; s++) wr(AW'(s), DW'(32'hA00000 + s * 16 + 32'hFF000000));
    for (int k = 0; k < WIN_N; k++) expWin[k] = PIX_W'(32'hA00000 + (k + 1) * 16);
    rd(4, d); check("R11 slot readback", d, {8'h0, expWin[3]});
    wr(0, 32'b01101); // start, irq enable, full mode
    check("R2 launch strobe", winValid, 1);
    check("R2 window", winPixels, packWin());
    rd(0, d); check("R4 busy set, start reads 0", d, 32'b11100);
    @(negedge clk);
    check("R2 strobe one cycle", winValid, 0);
  endtask

  task automatic t_start_busy();
    logic [DW-1:0] d;
    wr(1, 32'h111111); wr(2, 32'h222222); wr(3, 32'h333333);
    wr(0, 32'b00101); // start in shift mode while busy
    check("R8 no launch", winValid, 0);
    @(negedge clk);
    check("R8 no late launch", winValid, 0);
    check("R8 window unchanged", winPixels, packWin());
    rd(0, d); check("R8 busy kept, mode bit stored", d, 32'b10100);
  endtask

  task automatic t_complete(input logic [PIX_W-1:0] p, input bit irqOn);
    logic [DW-1:0] d;
    complete(p);
    rd(10, d); check("R5 result", d, {8'h0, p});
    rd(0, d);  check("R5 done set busy clear", d[4:1], {1'b0, 1'b0, irqOn, 1'b1});
    check("R6 irq", irq, irqOn);
  endtask

  task automatic t_clear_w1c();
    logic [DW-1:0] d;
    wr(0, 32'b00110);
    rd(0, d); check("R7 done cleared by write one", d[1], 0);
    check("R7 irq cleared", irq, 0);
  endtask

  task automatic t_shift();
    logic [DW-1:0] d;
    wr(5, 32'hBADBAD); // slot outside the new column: must not matter
    for (int k = 0; k < 6; k++) expWin[k] = expWin[k + 3];
    expWin[6] = 24'h111111; expWin[7] = 24'h222222; expWin[8] = 24'h333333;
    wr(0, 32'b00101);
    check("R3 launch", winValid, 1);
    check("R3 shifted window", winPixels, packWin());
    rd(0, d); check("R4 busy in shift", d[4], 1);
  endtask

  task automatic t_hold_and_stray();
    logic [DW-1:0] d;
    rd(10, d); check("R9 result held while busy", d, 32'h00ABCDEF);
    t_complete(24'h123456, 1'b1);
    complete(24'h777777); // not busy: ignored
    rd(10, d); check("R9 stray valid ignored", d, 32'h00123456);
    wr(10, 32'h00999999);
    rd(10, d); check("R10 result read-only", d, 32'h00123456);
  endtask

  task automatic t_clear_by_start();
    logic [DW-1:0] d;
    check("R6 irq before restart", irq, 1);
    wr(1, 32'h444444); wr(2, 32'h555555); wr(3, 32'h666666);
    for (int k = 0; k < 6; k++) expWin[k] = expWin[k + 3];
    expWin[6] = 24'h444444; expWin[7] = 24'h555555; expWin[8] = 24'h666666;
    wr(0, 32'b00001); // start, interrupt disabled
    check("R7 irq cleared by start", irq, 0);
    check("R3 second shift", winPixels, packWin());
    rd(0, d); check("R7 done cleared by start", d[1], 0);
    t_complete(24'h0F0F0F, 1'b0);
    check("R6 irq gated by enable", irq, 0);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_load();
    t_start_busy();
    t_complete(24'hABCDEF, 1'b1);
    t_clear_w1c();
    t_shift();
    t_hold_and_stray();
    t_clear_by_start();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule